// File: doc/BRIEF.md
# Stall-Only Pipeline Hazard Controller

This block is the combinational hazard-control logic for a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) that has no operand bypass network. Each cycle it looks at the instruction waiting in decode and at the two older instructions still in flight in execute and memory. If either older instruction will write a register that the decode instruction reads, the decode instruction must wait. The block holds the program counter and the fetch/decode register, and it flushes decode so that a bubble moves on into execute.

A taken jump or branch, reported by resolution logic outside this block, makes the two younger instructions in fetch and decode wrong-path work. The block flushes both of them and leaves the program counter free to load the redirect target. The block decodes the major opcode of the decode instruction. Because of this, only register fields that the instruction actually reads can cause a stall.

Top module: `hzc_top`

## Requirements
- R1: When the jump input is low and no data hazard exists, all four outputs (if_flush, id_flush, pc_stall, ifid_stall) are 0.
- R2: When jump_taken is 1, if_flush and id_flush are 1 and pc_stall and ifid_stall are 0, whatever the register inputs are.
- R3: A hazard against execute exists when ex_wen is 1, ex_rd is non-zero, and ex_rd equals a source index that the decode instruction reads. With jump_taken low, this gives id_flush=1, pc_stall=1, ifid_stall=1 and if_flush=0.
- R4: A hazard against memory exists under the same conditions using mem_wen and mem_rd, and it gives the same outputs as R3.
- R5: A producer whose destination is register 0 never causes a stall, even when its write enable is 1.
- R6: A producer whose write enable is 0 never causes a stall, even when its destination matches.
- R7: Source usage follows id_opcode. 7'b1100011 (branch), 7'b0100011 (store) and 7'b0110011 (reg-reg ALU) read rs1 and rs2. 7'b1100111 (indirect jump), 7'b0000011 (load) and 7'b0010011 (reg-imm ALU) read rs1 only. Every other opcode, including 7'b0110111, 7'b0010111 and 7'b1101111, reads neither.
- R8: When a jump and a data hazard occur together, the outputs are those of R2.
- R9: pc_stall always equals ifid_stall, and if_flush is never 1 at the same time as a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| jump_taken | input | 1 | Taken jump or branch redirect this cycle |
| id_opcode | input | 7 | Major opcode of the decode-stage instruction |
| id_rs1 | input | 5 | First source index of the decode instruction |
| id_rs2 | input | 5 | Second source index of the decode instruction |
| ex_rd | input | 5 | Destination index of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| mem_rd | input | 5 | Destination index of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| if_flush | output | 1 | Flush the fetch/decode pipeline register |
| id_flush | output | 1 | Flush decode (bubble into execute) |
| pc_stall | output | 1 | Hold the program counter |
| ifid_stall | output | 1 | Hold the fetch/decode pipeline register |

## Verification
The assertions hold on every evaluation. They check that the stall pair stays equal, that a jump always wins, that the outputs are quiet when there is no cause, and that no per-producer match ever names register 0 or a producer that is not writing. They also check that a hazard only arises from an opcode that reads a register. Two things can only be shown by the bench's scenarios, where a behavioural model gives the expected outputs. The first is the opcode-to-usage table itself. The second is the exact stall patterns of real instruction sequences: back-to-back dependences, distance-two dependences through memory, writes to register 0, and a jump that lands on a hazard.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    parameter int REG_W = 5;
    parameter int OPC_W = 7;
    parameter int NUM_PROD = 2;

    typedef logic [REG_W-1:0] reg_idx_t;
    typedef logic [OPC_W-1:0] opcode_t;

    typedef struct packed {
        logic rd1;
        logic rd2;
    } src_use_t;

    typedef struct packed {
        logic     wen;
        reg_idx_t rd;
    } producer_t;

    typedef struct packed {
        logic if_flush;
        logic id_flush;
        logic pc_stall;
        logic ifid_stall;
    } ctrl_t;

    localparam opcode_t OPC_LUI    = 7'b0110111;
    localparam opcode_t OPC_AUIPC  = 7'b0010111;
    localparam opcode_t OPC_JAL    = 7'b1101111;
    localparam opcode_t OPC_JALR   = 7'b1100111;
    localparam opcode_t OPC_BRANCH = 7'b1100011;
    localparam opcode_t OPC_LOAD   = 7'b0000011;
    localparam opcode_t OPC_STORE  = 7'b0100011;
    localparam opcode_t OPC_OPIMM  = 7'b0010011;
    localparam opcode_t OPC_OP     = 7'b0110011;

    localparam reg_idx_t REG_ZERO = '0;

    function automatic logic writes_real_reg(input producer_t p);
        return p.wen && (p.rd != REG_ZERO);
    endfunction

endpackage

// File: rtl/hzc_src_decode.sv
module hzc_src_decode
    import hzc_pkg::*;
(
    input  opcode_t  opcode,
    output src_use_t use_o
);
    always_comb begin
        use_o = '0;
        unique case (opcode)
            OPC_BRANCH, OPC_STORE, OPC_OP: begin
                use_o.rd1 = 1'b1;
                use_o.rd2 = 1'b1;
            end
            OPC_JALR, OPC_LOAD, OPC_OPIMM: begin
                use_o.rd1 = 1'b1;
            end
            default: use_o = '0;
        endcase
    end
endmodule

// File: rtl/hzc_match.sv
module hzc_match
    import hzc_pkg::*;
#(
    parameter int NP = NUM_PROD
) (
    input  src_use_t              use_i,
    input  reg_idx_t              rs1,
    input  reg_idx_t              rs2,
    input  producer_t [NP-1:0]    prod,
    output logic      [NP-1:0]    hit_per,
    output logic                  hit
);
    for (genvar g = 0; g < NP; g++) begin : g_prod
        logic m1, m2;
        assign m1 = use_i.rd1 && (prod[g].rd == rs1);
        assign m2 = use_i.rd2 && (prod[g].rd == rs2);
        assign hit_per[g] = writes_real_reg(prod[g]) && (m1 || m2);

        always_comb begin
            assert_nozero_R5: assert (!hit_per[g] || prod[g].rd != REG_ZERO)
                else $error("producer %0d matched on register 0", g);
            assert_wen_R6: assert (!hit_per[g] || prod[g].wen)
                else $error("producer %0d matched without write enable", g);
        end
    end

    assign hit = |hit_per;
endmodule

// File: rtl/hzc_arbiter.sv
module hzc_arbiter
    import hzc_pkg::*;
(
    input  logic  jump,
    input  logic  hazard,
    output ctrl_t ctrl
);
    always_comb begin
        ctrl = '0;
        if (jump) begin
            ctrl.if_flush = 1'b1;
            ctrl.id_flush = 1'b1;
        end else if (hazard) begin
            ctrl.id_flush   = 1'b1;
            ctrl.pc_stall   = 1'b1;
            ctrl.ifid_stall = 1'b1;
        end
    end
endmodule

// File: rtl/hzc_top.sv
module hzc_top
    import hzc_pkg::*;
(
    input  logic       jump_taken,
    input  logic [6:0] id_opcode,
    input  logic [4:0] id_rs1,
    input  logic [4:0] id_rs2,
    input  logic [4:0] ex_rd,
    input  logic       ex_wen,
    input  logic [4:0] mem_rd,
    input  logic       mem_wen,
    output logic       if_flush,
    output logic       id_flush,
    output logic       pc_stall,
    output logic       ifid_stall
);
    src_use_t                 src_use;
    producer_t [NUM_PROD-1:0] prods;
    logic      [NUM_PROD-1:0] hit_per;
    logic                     hazard;
    ctrl_t                    ctrl;

    assign prods[0] = '{wen: ex_wen,  rd: ex_rd};
    assign prods[1] = '{wen: mem_wen, rd: mem_rd};

    hzc_src_decode u_dec (
        .opcode (id_opcode),
        .use_o  (src_use)
    );

    hzc_match #(.NP(NUM_PROD)) u_match (
        .use_i   (src_use),
        .rs1     (id_rs1),
        .rs2     (id_rs2),
        .prod    (prods),
        .hit_per (hit_per),
        .hit     (hazard)
    );

    hzc_arbiter u_arb (
        .jump   (jump_taken),
        .hazard (hazard),
        .ctrl   (ctrl)
    );

    assign if_flush   = ctrl.if_flush;
    assign id_flush   = ctrl.id_flush;
    assign pc_stall   = ctrl.pc_stall;
    assign ifid_stall = ctrl.ifid_stall;

    always_comb begin
        assert_idle_R1: assert (jump_taken || hazard || ctrl == '0)
            else $error("outputs active without cause");
        assert_jump_R2: assert (!jump_taken || (if_flush && id_flush && !pc_stall && !ifid_stall))
            else $error("jump did not produce flush-only pattern");
        assert_stall_R3: assert (jump_taken || !hazard || (id_flush && pc_stall && !if_flush))
            else $error("hazard did not stall");
        assert_use_R7: assert (!hazard || src_use.rd1 || src_use.rd2)
            else $error("hazard from opcode that reads no register");
        assert_pair_R9: assert (pc_stall == ifid_stall && !(if_flush && pc_stall))
            else $error("stall pair inconsistent");
    end
endmodule

// File: tb/hzc_top_tb.sv
module hzc_top_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       jump_taken;
    logic [6:0] id_opcode;
    logic [4:0] id_rs1, id_rs2, ex_rd, mem_rd;
    logic       ex_wen, mem_wen;
    logic       if_flush, id_flush, pc_stall, ifid_stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    hzc_top u_dut (
        .jump_taken (jump_taken),
        .id_opcode  (id_opcode),
        .id_rs1     (id_rs1),
        .id_rs2     (id_rs2),
        .ex_rd      (ex_rd),
        .ex_wen     (ex_wen),
        .mem_rd     (mem_rd),
        .mem_wen    (mem_wen),
        .if_flush   (if_flush),
        .id_flush   (id_flush),
        .pc_stall   (pc_stall),
        .ifid_stall (ifid_stall)
    );

    // Behavioural model: integer source counts per opcode
    function automatic int reads_count(input logic [6:0] op);
        case (op)
            7'b1100011, 7'b0100011, 7'b0110011: return 2;
            7'b1100111, 7'b0000011, 7'b0010011: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit depends(input int n, input int r1, input int r2,
                                   input bit w, input int d);
        if (!w || d == 0) return 0;
        if (n >= 1 && d == r1) return 1;
        if (n >= 2 && d == r2) return 1;
        return 0;
    endfunction

    function automatic logic [3:0] model(input bit j, input logic [6:0] op,
                                         input int r1, input int r2,
                                         input bit we, input int de,
                                         input bit wm, input int dm);
        int n;
        n = reads_count(op);
        if (j) return 4'b1100;
        if (depends(n, r1, r2, we, de) || depends(n, r1, r2, wm, dm)) return 4'b0111;
        return 4'b0000;
    endfunction

    task automatic apply(input string tag, input bit j, input logic [6:0] op,
                         input int r1, input int r2, input bit we, input int de,
                         input bit wm, input int dm);
        logic [3:0] exp, act;
        @(negedge clk);
        jump_taken = j; id_opcode = op;
        id_rs1 = r1[4:0]; id_rs2 = r2[4:0];
        ex_wen = we; ex_rd = de[4:0];
        mem_wen = wm; mem_rd = dm[4:0];
        exp = model(j, op, r1, r2, we, de, wm, dm);
        #2;
        act = {if_flush, id_flush, pc_stall, ifid_stall};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (if,id,pc,ifid)", tag, act, exp);
        end
    endtask

    initial begin
        int seed;
        jump_taken = 0; id_opcode = 7'b0010011; id_rs1 = 0; id_rs2 = 0;
        ex_rd = 0; ex_wen = 0; mem_rd = 0; mem_wen = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1 quiet state
        apply("R1 idle", 0, 7'b0110011, 1, 2, 0, 0, 0, 0);
        apply("R1 no-match", 0, 7'b0110011, 1, 2, 1, 3, 1, 4);
        // R3 back-to-back dependent add on rs1 and rs2
        apply("R3 ex rs1", 0, 7'b0110011, 5, 6, 1, 5, 0, 0);
        apply("R3 ex rs2", 0, 7'b0110011, 5, 6, 1, 6, 0, 0);
        // R4 distance two through memory
        apply("R4 mem rs1", 0, 7'b0000011, 9, 0, 0, 9, 1, 9);
        apply("R4 mem rs2", 0, 7'b0100011, 1, 12, 1, 3, 1, 12);
        // R5 writes to register 0
        apply("R5 ex x0", 0, 7'b0110011, 0, 0, 1, 0, 0, 0);
        apply("R5 mem x0", 0, 7'b1100011, 0, 0, 0, 0, 1, 0);
        // R6 non-writing producer
        apply("R6 ex nowen", 0, 7'b0110011, 7, 8, 0, 7, 0, 8);
        // R7 usage decoding
        apply("R7 opimm rs2 ignored", 0, 7'b0010011, 1, 14, 1, 14, 1, 14);
        apply("R7 jalr rs1", 0, 7'b1100111, 14, 0, 1, 14, 0, 0);
        apply("R7 lui none", 0, 7'b0110111, 3, 3, 1, 3, 1, 3);
        apply("R7 auipc none", 0, 7'b0010111, 3, 3, 1, 3, 1, 3);
        apply("R7 jal none", 0, 7'b1101111, 3, 3, 1, 3, 1, 3);
        apply("R7 branch rs2", 0, 7'b1100011, 2, 31, 0, 0, 1, 31);
        // R2 jump alone, R8 jump over hazard
        apply("R2 jump", 1, 7'b0010011, 1, 2, 0, 0, 0, 0);
        apply("R8 jump+hazard", 1, 7'b0110011, 5, 6, 1, 5, 1, 6);
        apply("R9 after jump", 0, 7'b0110011, 5, 6, 1, 5, 0, 0);
        // R9 mixed sweep against the model
        seed = 17;
        for (int i = 0; i < 300; i++) begin
            int v;
            logic [6:0] ops [0:9];
            ops = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011, 7'b1100011,
                    7'b1100111, 7'b0110111, 7'b0010111, 7'b1101111, 7'b1110011};
            v = $urandom(seed + i);
            apply("R9 sweep", (v % 7) == 0, ops[(v >> 3) % 10],
                  (v >> 8) & 3, (v >> 10) & 3, v[12], (v >> 13) & 3,
                  v[15], (v >> 16) & 3);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule